// File: doc/BRIEF.md
# Two-Wire Bus Recovery Sequencer

This block frees a two-wire serial bus that a slave device has left stuck, typically with the data line held low partway through a byte. On a start request it drives a fixed pattern through two open-drain pull-low enables. First it gives nine clock pulses on the clock line. Then it builds a STOP condition: the clock is released while data is held low, and after that data is released.

Each step of the pattern lasts one timing interval. The interval is set in system clock cycles by a parameter, so a 5 microsecond step at any clock frequency is just a matter of choosing the parameter value. When the pattern ends, a one-cycle done pulse is raised. A status word reports the two pull-low enables and the sensed levels of both lines. The sensed levels first pass through a short synchronizer. Deciding when recovery is needed, and moving normal bytes, belong to other logic.

Top module: `bus_recovery`

## Requirements
- R1: During reset and after reset (active-low `rstN`, asynchronous), both pull-low enables are 0 (line released), `doneFlag` is 0 and status bits 8 and 9 are 0. A reset in the middle of a sequence releases both lines at once.
- R2: A `startPulse` accepted while idle begins clock pulses. In each pulse `sclPullLow` is 0 for exactly INTERVAL_CYCLES cycles and then 1 for exactly INTERVAL_CYCLES cycles, while `sdaPullLow` stays 0. The first released interval begins on the clock edge that samples the start.
- R3: Exactly PULSE_COUNT pulses (default 9) are produced before the STOP phase begins.
- R4: After the last pulse, `sclPullLow` stays 1 and `sdaPullLow` becomes 1 for one interval.
- R5: Then `sclPullLow` becomes 0 while `sdaPullLow` stays 1 for one interval (STOP setup).
- R6: Then both enables are 0 for one interval. After that interval, `doneFlag` is 1 for exactly one cycle, and the block returns to idle.
- R7: A `startPulse` that arrives while a sequence is running has no effect: the pattern continues unchanged and no second sequence follows.
- R8: `statusWord` has bit 8 = `sdaPullLow`, bit 9 = `sclPullLow`, bit 10 = sensed data level and bit 11 = sensed clock level, each sensed level delayed by SYNC_STAGES clock edges. All other bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startPulse | input | 1 | One-cycle request to run the recovery pattern |
| sclSense | input | 1 | Sensed level of the clock line (asynchronous) |
| sdaSense | input | 1 | Sensed level of the data line (asynchronous) |
| sclPullLow | output | 1 | 1 pulls the clock line low, 0 releases it |
| sdaPullLow | output | 1 | 1 pulls the data line low, 0 releases it |
| doneFlag | output | 1 | One-cycle pulse when the pattern completes |
| statusWord | output | 16 | Enables and synchronized sensed levels, bits 8 to 11 |

## Verification
The embedded properties assume that `startPulse` is synchronous to `clk` and that INTERVAL_CYCLES and PULSE_COUNT are at least 1. The sensed line levels may change at any time, and no property depends on them. The stimulus changes every input only on the falling clock edge and keeps the start request to one cycle. It deliberately raises start in the middle of a run, which is the one case of busy-time input the block has to tolerate. It holds the sensed data level low to mimic a stuck slave, and the pattern does not depend on it.

// File: rtl/busrec_pkg.sv
`timescale 1ns/1ps
package busrec_pkg;

  typedef enum logic [2:0] {
    PH_IDLE     = 3'd0,
    PH_CLK_HIGH = 3'd1,
    PH_CLK_LOW  = 3'd2,
    PH_STOP_SDA = 3'd3,
    PH_STOP_SCL = 3'd4,
    PH_STOP_END = 3'd5
  } phase_e;

  // Strobes from the sequencer control to the datapath.
  typedef struct packed {
    logic phaseLoad;  // reload interval timer and latch new enables
    logic sclLow;     // enable value for the clock line on phaseLoad
    logic sdaLow;     // enable value for the data line on phaseLoad
    logic pulseClr;   // zero the pulse counter
    logic pulseInc;   // advance the pulse counter
    logic finish;     // raise the done pulse
  } seq_strobe_t;

  localparam int STATUS_W       = 16;
  localparam int ST_SDA_OVR_BIT = 8;
  localparam int ST_SCL_OVR_BIT = 9;
  localparam int ST_SDA_IN_BIT  = 10;
  localparam int ST_SCL_IN_BIT  = 11;

endpackage

// File: rtl/busrec_ctrl.sv
`timescale 1ns/1ps
module busrec_ctrl
  import busrec_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startPulse,
  input  logic        intervalEnd,
  input  logic        lastPulse,
  output seq_strobe_t strobes
);

  phase_e phase, phaseNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= PH_IDLE;
    else       phase <= phaseNext;
  end

  always_comb begin
    phaseNext = phase;
    strobes   = '0;
    unique case (phase)
      PH_IDLE: begin
        if (startPulse) begin
          phaseNext         = PH_CLK_HIGH;
          strobes.phaseLoad = 1'b1;
          strobes.pulseClr  = 1'b1;
        end
      end
      PH_CLK_HIGH: begin
        if (intervalEnd) begin
          phaseNext         = PH_CLK_LOW;
          strobes.phaseLoad = 1'b1;
          strobes.sclLow    = 1'b1;
        end
      end
      PH_CLK_LOW: begin
        if (intervalEnd) begin
          strobes.phaseLoad = 1'b1;
          if (lastPulse) begin
            phaseNext      = PH_STOP_SDA;
            strobes.sclLow = 1'b1;
            strobes.sdaLow = 1'b1;
          end else begin
            phaseNext        = PH_CLK_HIGH;
            strobes.pulseInc = 1'b1;
          end
        end
      end
      PH_STOP_SDA: begin
        if (intervalEnd) begin
          phaseNext         = PH_STOP_SCL;
          strobes.phaseLoad = 1'b1;
          strobes.sdaLow    = 1'b1;
        end
      end
      PH_STOP_SCL: begin
        if (intervalEnd) begin
          phaseNext         = PH_STOP_END;
          strobes.phaseLoad = 1'b1;
        end
      end
      PH_STOP_END: begin
        if (intervalEnd) begin
          phaseNext      = PH_IDLE;
          strobes.finish = 1'b1;
        end
      end
      default: phaseNext = PH_IDLE;
    endcase
  end

  // R2: a running phase only moves on when the datapath timer expires
  p_phase_held_r2: assert property (@(posedge clk) disable iff (!rstN)
    (phase != PH_IDLE && !intervalEnd) |=> $stable(phase));

endmodule

// File: rtl/busrec_dp.sv
`timescale 1ns/1ps
module busrec_dp
  import busrec_pkg::*;
#(
  parameter int INTERVAL_CYCLES = 500,
  parameter int PULSE_COUNT     = 9,
  parameter int SYNC_STAGES     = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  seq_strobe_t         strobes,
  input  logic                sclSense,
  input  logic                sdaSense,
  output logic                intervalEnd,
  output logic                lastPulse,
  output logic                sclPullLow,
  output logic                sdaPullLow,
  output logic                doneFlag,
  output logic [STATUS_W-1:0] statusWord
);

  localparam int TIMER_W = (INTERVAL_CYCLES > 1) ? $clog2(INTERVAL_CYCLES) : 1;
  localparam int PULSE_W = (PULSE_COUNT > 1) ? $clog2(PULSE_COUNT) : 1;
  localparam logic [TIMER_W-1:0] TIMER_RELOAD = TIMER_W'(INTERVAL_CYCLES - 1);
  localparam logic [PULSE_W-1:0] PULSE_LAST   = PULSE_W'(PULSE_COUNT - 1);

  logic [TIMER_W-1:0] intervalTimer;
  logic [PULSE_W-1:0] pulseCnt;
  logic               sclSeen, sdaSeen;

  // Interval timer: reloads on every phase change, counts down to zero.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   intervalTimer <= '0;
    else if (strobes.phaseLoad)  intervalTimer <= TIMER_RELOAD;
    else if (intervalTimer != 0) intervalTimer <= intervalTimer - 1'b1;
  end
  assign intervalEnd = (intervalTimer == '0);

  // Clock pulse counter.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 pulseCnt <= '0;
    else if (strobes.pulseClr) pulseCnt <= '0;
    else if (strobes.pulseInc) pulseCnt <= pulseCnt + 1'b1;
  end
  assign lastPulse = (pulseCnt == PULSE_LAST);

  // Pull-low enables and completion pulse.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPullLow <= 1'b0;
      sdaPullLow <= 1'b0;
      doneFlag   <= 1'b0;
    end else begin
      doneFlag <= strobes.finish;
      if (strobes.phaseLoad) begin
        sclPullLow <= strobes.sclLow;
        sdaPullLow <= strobes.sdaLow;
      end
    end
  end

  // Synchronizers for the sensed line levels.
  generate
    if (SYNC_STAGES == 0) begin : g_nosync
      assign sclSeen = sclSense;
      assign sdaSeen = sdaSense;
    end else begin : g_sync
      logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclPipe <= '0;
          sdaPipe <= '0;
        end else begin
          sclPipe[0] <= sclSense;
          sdaPipe[0] <= sdaSense;
          for (int i = 1; i < SYNC_STAGES; i++) begin
            sclPipe[i] <= sclPipe[i-1];
            sdaPipe[i] <= sdaPipe[i-1];
          end
        end
      end
      assign sclSeen = sclPipe[SYNC_STAGES-1];
      assign sdaSeen = sdaPipe[SYNC_STAGES-1];
    end
  endgenerate

  always_comb begin
    statusWord                 = '0;
    statusWord[ST_SDA_OVR_BIT] = sdaPullLow;
    statusWord[ST_SCL_OVR_BIT] = sclPullLow;
    statusWord[ST_SDA_IN_BIT]  = sdaSeen;
    statusWord[ST_SCL_IN_BIT]  = sclSeen;
  end

  p_timer_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    intervalTimer <= TIMER_RELOAD);

  p_pulse_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    pulseCnt <= PULSE_LAST);

  p_sda_after_scl_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaPullLow) |-> sclPullLow);

  p_stop_setup_r5: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(sclPullLow) && $past(sdaPullLow)) |-> sdaPullLow);

  p_done_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    doneFlag |=> !doneFlag);

  p_start_when_free_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.pulseClr |-> (!sclPullLow && !sdaPullLow));

endmodule

// File: rtl/bus_recovery.sv
`timescale 1ns/1ps
module bus_recovery #(
  parameter int INTERVAL_CYCLES = 500,
  parameter int PULSE_COUNT     = 9,
  parameter int SYNC_STAGES     = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        startPulse,
  input  logic        sclSense,
  input  logic        sdaSense,
  output logic        sclPullLow,
  output logic        sdaPullLow,
  output logic        doneFlag,
  output logic [15:0] statusWord
);
  import busrec_pkg::*;

  seq_strobe_t strobes;
  logic        intervalEnd;
  logic        lastPulse;

  busrec_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .startPulse  (startPulse),
    .intervalEnd (intervalEnd),
    .lastPulse   (lastPulse),
    .strobes     (strobes)
  );

  busrec_dp #(
    .INTERVAL_CYCLES (INTERVAL_CYCLES),
    .PULSE_COUNT     (PULSE_COUNT),
    .SYNC_STAGES     (SYNC_STAGES)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .sclSense    (sclSense),
    .sdaSense    (sdaSense),
    .intervalEnd (intervalEnd),
    .lastPulse   (lastPulse),
    .sclPullLow  (sclPullLow),
    .sdaPullLow  (sdaPullLow),
    .doneFlag    (doneFlag),
    .statusWord  (statusWord)
  );

endmodule

// File: tb/bus_recovery_tb.sv
`timescale 1ns/1ps
module bus_recovery_tb;

  localparam int N      = 4;
  localparam int PULSES = 9;
  localparam int PHASES = 2 * PULSES + 3;

  // Expected {sclPullLow, sdaPullLow} per interval of one run.
  localparam logic [1:0] PHASE_EXP [PHASES] = '{
    2'b00, 2'b10, 2'b00, 2'b10, 2'b00, 2'b10, 2'b00, 2'b10, 2'b00,
    2'b10, 2'b00, 2'b10, 2'b00, 2'b10, 2'b00, 2'b10, 2'b00, 2'b10,
    2'b11, 2'b01, 2'b00
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startPulse = 1'b0;
  logic        sclSense = 1'b1;
  logic        sdaSense = 1'b0;
  logic        sclPullLow, sdaPullLow, doneFlag;
  logic [15:0] statusWord;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  bus_recovery #(.INTERVAL_CYCLES(N), .PULSE_COUNT(PULSES), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rstN(rstN), .startPulse(startPulse),
    .sclSense(sclSense), .sdaSense(sdaSense),
    .sclPullLow(sclPullLow), .sdaPullLow(sdaPullLow),
    .doneFlag(doneFlag), .statusWord(statusWord)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string tagOf(input int p);
    if (p < 2 * PULSES - 2) return "R2";
    if (p < 2 * PULSES)     return "R3";
    if (p == 2 * PULSES)    return "R4";
    if (p == 2 * PULSES + 1) return "R5";
    return "R6";
  endfunction

  // Run one sequence; injectAt >= 0 raises start at that cycle offset (R7).
  task automatic runSeq(input int injectAt);
    startPulse = 1'b1;
    @(negedge clk);
    for (int p = 0; p < PHASES; p++) begin
      for (int c = 0; c < N; c++) begin
        int t;
        t = p * N + c;
        startPulse = (t == injectAt);
        chk(tagOf(p), {13'd0, doneFlag, sclPullLow, sdaPullLow},
            {13'd0, 1'b0, PHASE_EXP[p]});
        if (c == 0)
          chk("R8", statusWord & 16'hF3FF,
              {6'd0, PHASE_EXP[p], 8'd0});
        @(negedge clk);
      end
    end
    startPulse = 1'b0;
    chk("R6", {13'd0, doneFlag, sclPullLow, sdaPullLow}, 16'h0004);
    @(negedge clk);
    chk("R6", {15'd0, doneFlag}, 16'h0000);
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R1: reset state
    @(negedge clk);
    chk("R1", {statusWord[9:8], 1'b0, doneFlag, sclPullLow, sdaPullLow}, 16'h0000);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", {13'd0, doneFlag, sclPullLow, sdaPullLow}, 16'h0000);

    // R8: sensed levels after synchronizer delay
    sclSense = 1'b1; sdaSense = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8", statusWord, 16'h0800);
    sdaSense = 1'b1;
    @(negedge clk);
    chk("R8", statusWord, 16'h0800);
    @(negedge clk);
    chk("R8", statusWord, 16'h0C00);
    sclSense = 1'b0; sdaSense = 1'b0;
    repeat (2) @(negedge clk);
    chk("R8", statusWord, 16'h0000);

    // R2..R6: plain run with stuck data line sensed low, clock sensed high
    sclSense = 1'b1;
    repeat (2) @(negedge clk);
    runSeq(-1);

    // R7: start requests while busy, mid-pulse and in the final interval
    runSeq(5 * N + 1);
    repeat (2 * N) begin
      @(negedge clk);
      chk("R7", {13'd0, doneFlag, sclPullLow, sdaPullLow}, 16'h0000);
    end
    runSeq(PHASES * N - 1);
    repeat (2 * N) begin
      @(negedge clk);
      chk("R7", {13'd0, doneFlag, sclPullLow, sdaPullLow}, 16'h0000);
    end

    // R1: reset in the middle of a run releases both lines
    startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    repeat (N + 1) @(negedge clk);
    chk("R2", {15'd0, sclPullLow}, 16'h0001);
    rstN = 1'b0;
    #1;
    chk("R1", {13'd0, doneFlag, sclPullLow, sdaPullLow}, 16'h0000);
    @(negedge clk);
    rstN = 1'b1;
    repeat (3 * N) begin
      @(negedge clk);
      chk("R1", {13'd0, doneFlag, sclPullLow, sdaPullLow}, 16'h0000);
    end

    // Back-to-back run after a reset still follows the full pattern
    runSeq(-1);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule